// File: doc/BRIEF.md
# Multicast Route Splitter

This unit computes the next-hop routing of a multicast head flit in one router of a two-dimensional mesh network-on-chip. The destination set arrives as a bitmap with one bit per node. The unit looks at where every listed destination sits relative to the current router and picks a set of output ports from local, north, south, east and west. For each chosen port it also produces a pruned bitmap, so that the replica sent through that port carries only the destinations it is responsible for.

Every router on the path repeats the same calculation on the reduced bitmap it receives. Destinations that share a direction therefore travel together as one copy for as long as possible. For example, from node 9 a packet for the whole top row leaves as a single copy heading north and fans out only once it reaches row 0. The result is held in an output register behind a valid/ready handshake, and the switch allocator consumes it from there.

Top module: `mc_route_split`

## Requirements
- R1: Node `n` sits at column `n % MESH_X` and row `n / MESH_X`. Row 0 is the northmost row. When the current node's own bit is set, the local port (mask bit 0) is selected, and that bit appears only in the local bitmap.
- R2: A destination in the current column goes to north (mask bit 1) if it lies in a lower-numbered row, and to south (mask bit 2) otherwise. A destination in the current row goes to east (mask bit 3) if its column is higher, and to west (mask bit 4) otherwise.
- R3: A diagonal destination goes to the vertical port on its side when at least one listed destination lies in the current column on that same vertical side. In every other case it goes to the horizontal port on its side.
- R4: The five per-port bitmaps never share a bit. When no error is flagged, their union equals the accepted input bitmap.
- R5: Mask bit p is set exactly when bitmap p is non-zero, so the number of replicas equals the population count of the mask.
- R6: The arrival-port input uses the mask bit numbering: 0 local, 1 north, 2 south, 3 east, 4 west. The arrival port is never set in the mask. A destination that would leave through it is dropped, and the error flag is raised.
- R7: An all-zero input bitmap produces an empty mask, all-zero bitmaps and a raised error flag.
- R8: A request is taken when `in_valid` and `in_ready` are both high. Its result appears with `out_valid` on the next clock. The result stays unchanged while `out_valid` is high and `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R9: During and right after reset, `out_valid`, `out_mask` and `out_err` are 0.
- R10: At node 9, a request from the local port for nodes {0,1,2,3} yields only the north port, carrying all four. At node 1, the same set arriving from the south yields local {1}, east {2,3} and west {0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Head flit request present |
| in_ready | output | 1 | Request can be taken this cycle |
| cur_x | input | XW (2) | Column of this router |
| cur_y | input | YW (2) | Row of this router |
| in_port | input | 3 | Port the packet arrived on (0 L, 1 N, 2 S, 3 E, 4 W) |
| in_dest | input | NODES (16) | Destination bitmap, bit n for node n |
| out_valid | output | 1 | Registered result present |
| out_ready | input | 1 | Switch allocator takes the result |
| out_mask | output | 5 | Selected output ports |
| out_maps | output | 5*NODES (80) | Per-port bitmaps, port p at bits [p*NODES +: NODES] |
| out_err | output | 1 | Empty request or destination dropped at arrival port |

## Verification
Assertions check on every cycle that the per-port bitmaps are disjoint and that, without an error, their union matches the accepted bitmap. They also check that the mask agrees with the bitmaps, that the arrival port stays deselected, that an empty request yields an empty mask with an error, and that the registered result holds under backpressure. Only the bench's scenarios can show that each destination goes to the right direction. That covers the choice between a vertical and a horizontal port for diagonal destinations, which depends on the other destinations in the list, and the two-hop fan-out example. The bench sweeps every node and arrival port against single, empty, full and pseudo-random bitmaps.

// File: rtl/mc_route_pkg.sv
package mc_route_pkg;
   localparam int NPORT  = 5;
   localparam int PORT_W = 3;
   localparam int P_LOC  = 0;
   localparam int P_N    = 1;
   localparam int P_S    = 2;
   localparam int P_E    = 3;
   localparam int P_W    = 4;
endpackage

// File: rtl/mc_dest_classify.sv
// Places each node relative to the current router.
module mc_dest_classify #(
   parameter int MESH_X = 4,
   parameter int MESH_Y = 4,
   localparam int NODES = MESH_X * MESH_Y,
   localparam int XW    = $clog2(MESH_X),
   localparam int YW    = $clog2(MESH_Y)
) (
   input  logic [XW-1:0]    cur_x,
   input  logic [YW-1:0]    cur_y,
   output logic [NODES-1:0] at_self,
   output logic [NODES-1:0] col_n,
   output logic [NODES-1:0] col_s,
   output logic [NODES-1:0] row_e,
   output logic [NODES-1:0] row_w,
   output logic [NODES-1:0] quad_ne,
   output logic [NODES-1:0] quad_nw,
   output logic [NODES-1:0] quad_se,
   output logic [NODES-1:0] quad_sw
);
   for (genvar i = 0; i < NODES; i++) begin : g_node
      localparam logic [XW-1:0] IX = XW'(i % MESH_X);
      localparam logic [YW-1:0] IY = YW'(i / MESH_X);
      logic same_x, same_y, to_e, to_w, to_n, to_s;
      assign same_x = (cur_x == IX);
      assign same_y = (cur_y == IY);
      assign to_e   = (cur_x <  IX);
      assign to_w   = (cur_x >  IX);
      assign to_n   = (cur_y >  IY);
      assign to_s   = (cur_y <  IY);
      assign at_self[i] = same_x & same_y;
      assign col_n[i]   = same_x & to_n;
      assign col_s[i]   = same_x & to_s;
      assign row_e[i]   = same_y & to_e;
      assign row_w[i]   = same_y & to_w;
      assign quad_ne[i] = to_n & to_e;
      assign quad_nw[i] = to_n & to_w;
      assign quad_se[i] = to_s & to_e;
      assign quad_sw[i] = to_s & to_w;
   end
endmodule

// File: rtl/mc_port_select.sv
// Assigns every listed destination to one output port and splits the bitmap.
module mc_port_select
   import mc_route_pkg::*;
#(
   parameter int NODES = 16
) (
   input  logic [NODES-1:0]       dest,
   input  logic [PORT_W-1:0]      in_port,
   input  logic [NODES-1:0]       at_self,
   input  logic [NODES-1:0]       col_n,
   input  logic [NODES-1:0]       col_s,
   input  logic [NODES-1:0]       row_e,
   input  logic [NODES-1:0]       row_w,
   input  logic [NODES-1:0]       quad_ne,
   input  logic [NODES-1:0]       quad_nw,
   input  logic [NODES-1:0]       quad_se,
   input  logic [NODES-1:0]       quad_sw,
   output logic [NPORT-1:0]       mask,
   output logic [NPORT*NODES-1:0] maps,
   output logic                   err
);
   logic             any_n, any_s;
   logic [NODES-1:0] raw [NPORT];
   logic [NPORT-1:0] dropped;

   assign any_n = |(dest & col_n);
   assign any_s = |(dest & col_s);

   always_comb begin
      raw[P_LOC] = dest & at_self;
      raw[P_N]   = dest & (col_n | (any_n ? (quad_ne | quad_nw) : '0));
      raw[P_S]   = dest & (col_s | (any_s ? (quad_se | quad_sw) : '0));
      raw[P_E]   = dest & (row_e | (any_n ? '0 : quad_ne) | (any_s ? '0 : quad_se));
      raw[P_W]   = dest & (row_w | (any_n ? '0 : quad_nw) | (any_s ? '0 : quad_sw));
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic keep;
      assign keep       = (in_port != PORT_W'(p));
      assign maps[p*NODES +: NODES] = keep ? raw[p] : '0;
      assign mask[p]    = keep & (|raw[p]);
      assign dropped[p] = ~keep & (|raw[p]);
   end

   assign err = (dest == '0) | (|dropped);
endmodule

// File: rtl/mc_out_stage.sv
// One-entry registered stage with a valid/ready handshake.
module mc_out_stage #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);
   if (W < 1) begin : g_bad_w
      $error("mc_out_stage: W must be positive");
   end

   assign in_ready = ~out_valid | out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else if (in_ready) begin
         out_valid <= in_valid;
         if (in_valid) out_data <= in_data;
      end
   end

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/mc_route_split.sv
// Multicast route computation and destination splitting for one mesh router.
module mc_route_split
   import mc_route_pkg::*;
#(
   parameter int MESH_X = 4,
   parameter int MESH_Y = 4,
   localparam int NODES = MESH_X * MESH_Y,
   localparam int XW    = $clog2(MESH_X),
   localparam int YW    = $clog2(MESH_Y),
   localparam int DW    = 1 + NPORT * NODES + NPORT
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [XW-1:0]          cur_x,
   input  logic [YW-1:0]          cur_y,
   input  logic [PORT_W-1:0]      in_port,
   input  logic [NODES-1:0]       in_dest,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [NPORT-1:0]       out_mask,
   output logic [NPORT*NODES-1:0] out_maps,
   output logic                   out_err
);
   if (MESH_X < 2 || MESH_Y < 2) begin : g_bad_mesh
      $error("mc_route_split: mesh needs at least 2 columns and 2 rows");
   end

   logic [NODES-1:0] at_self, col_n, col_s, row_e, row_w;
   logic [NODES-1:0] quad_ne, quad_nw, quad_se, quad_sw;
   logic [NPORT-1:0]       c_mask;
   logic [NPORT*NODES-1:0] c_maps;
   logic                   c_err;
   logic [DW-1:0]          q_data;

   mc_dest_classify #(.MESH_X(MESH_X), .MESH_Y(MESH_Y)) u_class (
      .cur_x(cur_x), .cur_y(cur_y), .at_self(at_self),
      .col_n(col_n), .col_s(col_s), .row_e(row_e), .row_w(row_w),
      .quad_ne(quad_ne), .quad_nw(quad_nw), .quad_se(quad_se), .quad_sw(quad_sw)
   );

   mc_port_select #(.NODES(NODES)) u_sel (
      .dest(in_dest), .in_port(in_port), .at_self(at_self),
      .col_n(col_n), .col_s(col_s), .row_e(row_e), .row_w(row_w),
      .quad_ne(quad_ne), .quad_nw(quad_nw), .quad_se(quad_se), .quad_sw(quad_sw),
      .mask(c_mask), .maps(c_maps), .err(c_err)
   );

   mc_out_stage #(.W(DW)) u_out (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_data({c_err, c_maps, c_mask}),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_data(q_data)
   );

   assign out_mask = q_data[NPORT-1:0];
   assign out_maps = q_data[NPORT +: NPORT*NODES];
   assign out_err  = q_data[DW-1];

   // Checker logic: union and pairwise overlap of the registered bitmaps.
   logic [NODES-1:0] seen, ovl;
   always_comb begin
      seen = '0;
      ovl  = '0;
      for (int p = 0; p < NPORT; p++) begin
         ovl  = ovl  | (seen & out_maps[p*NODES +: NODES]);
         seen = seen | out_maps[p*NODES +: NODES];
      end
   end

   // R4
   disjoint_maps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (ovl == '0));

   // R4
   union_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_err || (seen == $past(in_dest))));

   for (genvar p = 0; p < NPORT; p++) begin : g_mask_chk
      // R5
      mask_matches_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (out_mask[p] == (|out_maps[p*NODES +: NODES])));
   end

   // R6
   no_return_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (in_port < PORT_W'(NPORT)))
         |=> !out_mask[$past(in_port)]);

   // R7
   empty_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (in_dest == '0)) |=> (out_err && (out_mask == '0)));
endmodule

// File: tb/mc_route_split_tb.sv
module mc_route_split_tb;
   localparam int MX = 4;
   localparam int NN = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [1:0]  cur_x = '0;
   logic [1:0]  cur_y = '0;
   logic [2:0]  in_port = '0;
   logic [15:0] in_dest = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [4:0]  out_mask;
   logic [79:0] out_maps;
   logic        out_err;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   mc_route_split u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .cur_x(cur_x), .cur_y(cur_y), .in_port(in_port), .in_dest(in_dest),
      .out_valid(out_valid), .out_ready(out_ready), .out_mask(out_mask),
      .out_maps(out_maps), .out_err(out_err)
   );

   // Expected result from coordinates, per the requirement text.
   function automatic void model(input int x, input int y, input int port,
                                 input logic [15:0] d, output logic [4:0] m,
                                 output logic [79:0] mp, output logic e);
      bit has_n = 0, has_s = 0;
      for (int j = 0; j < NN; j++) begin
         if (d[j] && (j % MX) == x && (j / MX) < y) has_n = 1;
         if (d[j] && (j % MX) == x && (j / MX) > y) has_s = 1;
      end
      mp = '0;
      e  = (d == 16'h0);
      for (int j = 0; j < NN; j++) begin
         if (d[j]) begin
            int jx = j % MX, jy = j / MX, p;
            if (jx == x && jy == y)  p = 0;
            else if (jx == x)        p = (jy < y) ? 1 : 2;
            else if (jy == y)        p = (jx > x) ? 3 : 4;
            else if (jy < y)         p = has_n ? 1 : ((jx > x) ? 3 : 4);
            else                     p = has_s ? 2 : ((jx > x) ? 3 : 4);
            if (p == port) e = 1'b1;
            else mp[p*NN + j] = 1'b1;
         end
      end
      for (int p = 0; p < 5; p++) m[p] = |mp[p*NN +: NN];
   endfunction

   task automatic check(input string tag, input logic [4:0] em,
                        input logic [79:0] emp, input logic ee);
      bit bad = 0;
      vectors++;
      if (out_valid !== 1'b1) begin
         bad = 1;
         $display("FAIL %s out_valid act=%b exp=1", tag, out_valid);
      end
      if (out_mask !== em) begin
         bad = 1;
         $display("FAIL %s mask act=%b exp=%b (x=%0d y=%0d port=%0d dest=%h)",
                  tag, out_mask, em, cur_x, cur_y, in_port, in_dest);
      end
      for (int p = 0; p < 5; p++)
         if (out_maps[p*NN +: NN] !== emp[p*NN +: NN]) begin
            bad = 1;
            $display("FAIL %s map%0d act=%h exp=%h (x=%0d y=%0d port=%0d dest=%h)",
                     tag, p, out_maps[p*NN +: NN], emp[p*NN +: NN],
                     cur_x, cur_y, in_port, in_dest);
         end
      if (out_err !== ee) begin
         bad = 1;
         $display("FAIL %s err act=%b exp=%b", tag, out_err, ee);
      end
      if (bad) miscompares++;
   endtask

   task automatic apply(input int x, input int y, input int port,
                        input logic [15:0] d, input string tag);
      logic [4:0] m; logic [79:0] mp; logic e;
      model(x, y, port, d, m, mp, e);
      @(negedge clk);
      cur_x = 2'(x); cur_y = 2'(y); in_port = 3'(port); in_dest = d;
      in_valid = 1'b1;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      check(tag, m, mp, e);
   endtask

   task automatic next_rand();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic report();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         report();
      end
   end

   initial begin
      logic [4:0]  m; logic [79:0] mp; logic e;
      // R9 reset state
      repeat (3) @(posedge clk);
      #1;
      vectors++;
      if (out_valid !== 1'b0 || out_mask !== 5'b0 || out_err !== 1'b0 || in_ready !== 1'b1) begin
         miscompares++;
         $display("FAIL R9 reset act v=%b m=%b e=%b r=%b exp v=0 m=0 e=0 r=1",
                  out_valid, out_mask, out_err, in_ready);
      end
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      vectors++;
      if (out_valid !== 1'b0 || out_mask !== 5'b0 || out_err !== 1'b0) begin
         miscompares++;
         $display("FAIL R9 after reset act v=%b m=%b e=%b exp 0 0 0",
                  out_valid, out_mask, out_err);
      end

      // R10 directed two-hop example with literal expectations
      @(negedge clk);
      cur_x = 2'd1; cur_y = 2'd2; in_port = 3'd0; in_dest = 16'h000F; in_valid = 1'b1;
      @(posedge clk); #1; in_valid = 1'b0;
      check("R10 node9", 5'b00010, {16'h0, 16'h0, 16'h0, 16'h000F, 16'h0}, 1'b0);
      @(negedge clk);
      cur_x = 2'd1; cur_y = 2'd0; in_port = 3'd2; in_dest = 16'h000F; in_valid = 1'b1;
      @(posedge clk); #1; in_valid = 1'b0;
      check("R10 node1", 5'b11001, {16'h0001, 16'h000C, 16'h0, 16'h0, 16'h0002}, 1'b0);

      // Sweep: every node, every arrival port, many bitmaps
      for (int n = 0; n < NN; n++)
         for (int port = 0; port < 5; port++)
            for (int k = 0; k < 40; k++) begin
               int x = n % MX, y = n / MX;
               logic [15:0] d;
               string tag;
               if (k < 16) begin
                  int kx = k % MX, ky = k / MX, p;
                  d = 16'h1 << k;
                  if (kx == x && ky == y) begin p = 0; tag = "R1"; end
                  else if (kx == x)       begin p = (ky < y) ? 1 : 2; tag = "R2"; end
                  else if (ky == y)       begin p = (kx > x) ? 3 : 4; tag = "R2"; end
                  else                    begin p = (kx > x) ? 3 : 4; tag = "R3"; end
                  if (p == port) tag = "R6";
               end else if (k == 16) begin
                  d = 16'h0; tag = "R7";
               end else if (k == 17) begin
                  d = 16'hFFFF; tag = "R5";
               end else begin
                  next_rand();
                  d = lfsr;
                  next_rand();
                  if (k[0]) d = d & lfsr;
                  tag = k[1] ? "R4" : "R3";
               end
               apply(x, y, port, d, tag);
            end

      // R8 backpressure: drain, then hold result while out_ready is low
      @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      out_ready = 1'b0;
      cur_x = 2'd2; cur_y = 2'd1; in_port = 3'd0; in_dest = 16'h8421; in_valid = 1'b1;
      @(posedge clk); #1;
      model(2, 1, 0, 16'h8421, m, mp, e);
      check("R8 first", m, mp, e);
      @(negedge clk);
      cur_x = 2'd0; cur_y = 2'd3; in_port = 3'd3; in_dest = 16'h0F0F;
      for (int c = 0; c < 3; c++) begin
         @(posedge clk); #1;
         vectors++;
         if (in_ready !== 1'b0) begin
            miscompares++;
            $display("FAIL R8 in_ready act=%b exp=0", in_ready);
         end
         check("R8 hold", m, mp, e);
      end
      @(negedge clk); out_ready = 1'b1;
      @(posedge clk); #1; in_valid = 1'b0;
      model(0, 3, 3, 16'h0F0F, m, mp, e);
      check("R8 release", m, mp, e);

      done = 1'b1;
      report();
   end
endmodule